// File: doc/BRIEF.md
# Markov variable-to-fixed code decompressor

This block expands a compressed instruction stream in which every fixed-length codeword stands for a bit string of variable length. The meaning of a codeword depends on a Markov state: the decoder keeps a current state, looks the incoming codeword up in that state's codebook, emits the stored bit string one bit at a time and moves to the next state named by the same entry. The decompressed bits leave on a valid/ready stream and are packed into instruction words further downstream.

All codebooks are held in a writable table. Software loads it through a simple write port, so a different assignment of binary codewords to entries is a change of table contents and never a change of logic. With default parameters there are 32 states, 4-bit codewords (16 entries per codebook) and bit strings of 1 to 8 bits.

Top module: `vfx_decoder`

## Requirements
- R1: After reset the decoder is in state 0, `cw_ready_o` is 1 and `bit_valid_o` is 0.
- R2: After reset every table entry decodes to a single bit of value 0 with next state 0.
- R3: A codeword is accepted only while no bits of the previous entry remain: `cw_ready_o` is high exactly when `bit_valid_o` is low.
- R4: An entry with length field n (`wr_len_i`, 0..7) expands to n+1 bits, emitted from `wr_bits_i[n]` down to `wr_bits_i[0]`; the first bit is valid in the cycle after the codeword is accepted.
- R5: The codeword is decoded in the codebook of the current state, and on acceptance the current state becomes that entry's next-state field, so the same codeword yields different bits in different states.
- R6: While `bit_valid_o` is high and `bit_ready_i` is low, the same bit stays valid and unchanged in the next cycle.
- R7: Exactly one bit leaves per output handshake; after the last bit of an entry `cw_ready_o` is high in the next cycle and no extra bit appears.
- R8: A table write is taken only in a cycle where `cw_ready_o` is high and is used by every later lookup; a write while bits are pending is ignored.
- R9: The current state changes only in a cycle where a codeword is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cw_valid_i | input | 1 | Codeword present |
| cw_ready_o | output | 1 | Decoder can take a codeword |
| cw_i | input | 4 | Compressed codeword |
| wr_en_i | input | 1 | Table write strobe |
| wr_state_i | input | 5 | Codebook (Markov state) to write |
| wr_code_i | input | 4 | Entry within the codebook |
| wr_len_i | input | 3 | Bit string length minus one |
| wr_bits_i | input | 8 | Bit string, right aligned |
| wr_next_i | input | 5 | Next state after this entry |
| bit_valid_o | output | 1 | Output bit present |
| bit_ready_i | input | 1 | Sink takes the output bit |
| bit_o | output | 1 | Decompressed bit, first bit of a string first |

## Verification
The assertions watch, on every cycle, the exclusion between accepting a codeword and emitting bits, the first bit appearing one cycle after acceptance, a stalled bit holding its value, the down-count of pending bits, the reopening of the input after the last bit, and the state holding between acceptances. Only the bench scenarios can show that the emitted strings and their order are right, that the codebook of the current state is the one consulted, that reset contents decode to a single zero, and that writes while busy leave the table untouched; it does so by compressing random and directed codeword sequences with a behavioural model of the table and comparing every bit.

// File: rtl/vfx_pkg.sv
package vfx_pkg;
  localparam int unsigned DEF_CW_W     = 4;
  localparam int unsigned DEF_STATES   = 32;
  localparam int unsigned DEF_MAX_BITS = 8;
endpackage

// File: rtl/vfx_codebook.sv
module vfx_codebook #(
  parameter int unsigned CW_W     = 4,
  parameter int unsigned N_STATES = 32,
  parameter int unsigned ST_W     = 5,
  parameter int unsigned EW       = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [ST_W-1:0] wr_state_i,
  input  logic [CW_W-1:0] wr_code_i,
  input  logic [EW-1:0]   wr_data_i,
  input  logic [ST_W-1:0] rd_state_i,
  input  logic [CW_W-1:0] rd_code_i,
  output logic [EW-1:0]   rd_data_o
);
  localparam int unsigned N_CW = 1 << CW_W;

  logic [EW-1:0] bank_rd [N_STATES];

  for (genvar s = 0; s < N_STATES; s++) begin : g_bank
    logic [EW-1:0] mem_q [N_CW];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int c = 0; c < N_CW; c++) mem_q[c] <= '0;
      end else if (wr_en_i && wr_state_i == ST_W'(s)) begin
        mem_q[wr_code_i] <= wr_data_i;
      end
    end
    assign bank_rd[s] = mem_q[rd_code_i];
  end

  assign rd_data_o = bank_rd[rd_state_i];
endmodule

// File: rtl/vfx_state_reg.sv
module vfx_state_reg #(
  parameter int unsigned ST_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic [ST_W-1:0] next_i,
  output logic [ST_W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_o <= '0;
    else if (adv_i) state_o <= next_i;
  end
endmodule

// File: rtl/vfx_serializer.sv
module vfx_serializer #(
  parameter int unsigned MAX_BITS = 8,
  parameter int unsigned LEN_W    = 3,
  parameter int unsigned CNT_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [LEN_W-1:0]    len_m1_i,
  input  logic [MAX_BITS-1:0] bits_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic                bit_o,
  output logic [CNT_W-1:0]    left_o
);
  localparam logic [LEN_W-1:0] SH_MAX = LEN_W'(MAX_BITS - 1);

  logic [MAX_BITS-1:0] sr_q;
  logic [CNT_W-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      // left-align so the first bit of the string sits at the top
      sr_q  <= bits_i << (SH_MAX - len_m1_i);
      cnt_q <= CNT_W'(len_m1_i) + CNT_W'(1);
    end else if (valid_o && ready_i) begin
      sr_q  <= sr_q << 1;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign valid_o = (cnt_q != '0);
  assign bit_o   = sr_q[MAX_BITS-1];
  assign left_o  = cnt_q;
endmodule

// File: rtl/vfx_decoder.sv
module vfx_decoder
  import vfx_pkg::*;
#(
  parameter int unsigned CW_W     = DEF_CW_W,
  parameter int unsigned N_STATES = DEF_STATES,
  parameter int unsigned MAX_BITS = DEF_MAX_BITS,
  localparam int unsigned ST_W    = $clog2(N_STATES),
  localparam int unsigned LEN_W   = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cw_valid_i,
  output logic                cw_ready_o,
  input  logic [CW_W-1:0]     cw_i,
  input  logic                wr_en_i,
  input  logic [ST_W-1:0]     wr_state_i,
  input  logic [CW_W-1:0]     wr_code_i,
  input  logic [LEN_W-1:0]    wr_len_i,
  input  logic [MAX_BITS-1:0] wr_bits_i,
  input  logic [ST_W-1:0]     wr_next_i,
  output logic                bit_valid_o,
  input  logic                bit_ready_i,
  output logic                bit_o
);
  localparam int unsigned CNT_W = $clog2(MAX_BITS + 1);
  localparam int unsigned EW    = ST_W + LEN_W + MAX_BITS;

  logic [ST_W-1:0]     state_q;
  logic [CNT_W-1:0]    left_cnt;
  logic [EW-1:0]       rd_entry;
  logic [ST_W-1:0]     rd_next;
  logic [LEN_W-1:0]    rd_len;
  logic [MAX_BITS-1:0] rd_bits;
  logic                idle;
  logic                accept;
  logic                wr_go;

  assign idle       = (left_cnt == '0);
  assign cw_ready_o = idle;
  assign accept     = cw_valid_i && idle;
  // table only changes between strings
  assign wr_go      = wr_en_i && idle;

  vfx_codebook #(
    .CW_W(CW_W), .N_STATES(N_STATES), .ST_W(ST_W), .EW(EW)
  ) u_book (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_go),
    .wr_state_i (wr_state_i),
    .wr_code_i  (wr_code_i),
    .wr_data_i  ({wr_next_i, wr_len_i, wr_bits_i}),
    .rd_state_i (state_q),
    .rd_code_i  (cw_i),
    .rd_data_o  (rd_entry)
  );

  assign {rd_next, rd_len, rd_bits} = rd_entry;

  vfx_state_reg #(.ST_W(ST_W)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (accept),
    .next_i  (rd_next),
    .state_o (state_q)
  );

  vfx_serializer #(
    .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .len_m1_i (rd_len),
    .bits_i   (rd_bits),
    .ready_i  (bit_ready_i),
    .valid_o  (bit_valid_o),
    .bit_o    (bit_o),
    .left_o   (left_cnt)
  );
endmodule

// File: rtl/vfx_decoder_chk.sv
module vfx_decoder_chk #(
  parameter int unsigned ST_W  = 5,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cw_valid_i,
  input logic             cw_ready_o,
  input logic             bit_valid_o,
  input logic             bit_ready_i,
  input logic             bit_o,
  input logic [ST_W-1:0]  state_q,
  input logic [CNT_W-1:0] left_cnt
);
  a_r3_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_ready_o |-> !bit_valid_o);

  a_r3_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> !cw_ready_o);

  a_r4_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_valid_i && cw_ready_o) |=> bit_valid_o);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !bit_ready_i) |=> (bit_valid_o && $stable(bit_o)));

  a_r7_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && bit_ready_i) |=> (left_cnt == $past(left_cnt) - CNT_W'(1)));

  a_r7_reopen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && bit_ready_i && left_cnt == CNT_W'(1)) |=> cw_ready_o);

  a_r9_state_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cw_valid_i && cw_ready_o) |=> $stable(state_q));
endmodule

bind vfx_decoder vfx_decoder_chk #(.ST_W(ST_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cw_valid_i  (cw_valid_i),
  .cw_ready_o  (cw_ready_o),
  .bit_valid_o (bit_valid_o),
  .bit_ready_i (bit_ready_i),
  .bit_o       (bit_o),
  .state_q     (state_q),
  .left_cnt    (left_cnt)
);

// File: tb/sim_vfx_decoder.sv
`timescale 1ns/1ps
module sim_vfx_decoder;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cw_valid_i = 1'b0;
  logic       cw_ready_o;
  logic [3:0] cw_i = '0;
  logic       wr_en_i = 1'b0;
  logic [4:0] wr_state_i = '0;
  logic [3:0] wr_code_i = '0;
  logic [2:0] wr_len_i = '0;
  logic [7:0] wr_bits_i = '0;
  logic [4:0] wr_next_i = '0;
  logic       bit_valid_o;
  logic       bit_ready_i = 1'b0;
  logic       bit_o;

  always #10 clk = ~clk;

  vfx_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cw_valid_i(cw_valid_i), .cw_ready_o(cw_ready_o), .cw_i(cw_i),
    .wr_en_i(wr_en_i), .wr_state_i(wr_state_i), .wr_code_i(wr_code_i),
    .wr_len_i(wr_len_i), .wr_bits_i(wr_bits_i), .wr_next_i(wr_next_i),
    .bit_valid_o(bit_valid_o), .bit_ready_i(bit_ready_i), .bit_o(bit_o)
  );

  // behavioural model of the codebooks
  int  m_len [32][16];
  int  m_bits[32][16];
  int  m_next[32][16];
  int  m_state;
  bit  exp_q[$];
  int  total = 0;
  int  bad = 0;
  int  rdy_mode = 1;    // 0 random, 1 always, 2 never
  string cur_req = "R1";
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // output monitor: ready chosen at negedge, handshake sampled just after
  always @(negedge clk) begin
    case (rdy_mode)
      0: bit_ready_i = 1'($urandom % 2);
      1: bit_ready_i = 1'b1;
      default: bit_ready_i = 1'b0;
    endcase
    #1;
    if (rst_ni && bit_valid_o && bit_ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 extra bit", int'(bit_o), -1);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(bit_o == e, cur_req, int'(bit_o), int'(e));
      end
    end
  end

  task automatic send(input int cw);
    @(negedge clk);
    cw_valid_i = 1'b1;
    cw_i = 4'(cw);
    #2;
    while (!cw_ready_o) begin @(negedge clk); #2; end
    for (int k = m_len[m_state][cw]; k >= 0; k--) exp_q.push_back(1'((m_bits[m_state][cw] >> k) & 1));
    m_state = m_next[m_state][cw];
    @(posedge clk);
    #1;
    cw_valid_i = 1'b0;
    chk(bit_valid_o == 1'b1, "R4 first bit timing", int'(bit_valid_o), 1);
  endtask

  task automatic wr(input int s, input int c, input int l, input int b, input int n, output bit took);
    @(negedge clk);
    wr_en_i = 1'b1; wr_state_i = 5'(s); wr_code_i = 4'(c);
    wr_len_i = 3'(l); wr_bits_i = 8'(b); wr_next_i = 5'(n);
    #2;
    took = cw_ready_o;
    if (took) begin m_len[s][c] = l; m_bits[s][c] = b; m_next[s][c] = n; end
    @(posedge clk);
    #1;
    wr_en_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || bit_valid_o) @(negedge clk);
    repeat (2) @(negedge clk);
    #2;
    chk(exp_q.size() == 0 && !bit_valid_o && cw_ready_o, "R7 drained", int'(bit_valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit took;
    for (int s = 0; s < 32; s++)
      for (int c = 0; c < 16; c++) begin m_len[s][c] = 0; m_bits[s][c] = 0; m_next[s][c] = 0; end
    m_state = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #2;
    chk(cw_ready_o == 1'b1, "R1 ready after reset", int'(cw_ready_o), 1);
    chk(bit_valid_o == 1'b0, "R1 no bits after reset", int'(bit_valid_o), 0);

    // R2: untouched table gives one zero bit per codeword and stays in state 0
    cur_req = "R2";
    send(9); send(0); send(15);
    drain();

    // R4: longest and shortest strings, msb first
    cur_req = "R4";
    wr(0, 0, 7, 8'hA5, 0, took);
    chk(took, "R8 idle write taken", int'(took), 1);
    wr(0, 1, 0, 1, 0, took);
    wr(0, 2, 3, 8'h09, 0, took);
    send(0); send(1); send(2); send(0);
    drain();

    // R5: same codeword, different state, different string
    cur_req = "R5";
    wr(0, 3, 0, 1, 7, took);
    wr(7, 3, 1, 2, 0, took);
    send(3); send(3); send(3); send(3);
    drain();

    // R6: stalled bit holds
    rdy_mode = 2;
    send(0);
    begin
      bit b0;
      @(negedge clk); #2;
      b0 = bit_o;
      repeat (3) @(negedge clk);
      #2;
      chk(bit_valid_o && bit_o == b0, "R6 stall hold", int'(bit_o), int'(b0));
      chk(cw_ready_o == 1'b0, "R3 busy blocks input", int'(cw_ready_o), 0);
      // R8: write during pending bits must be ignored
      wr(0, 4, 7, 8'hFF, 5, took);
      chk(!took, "R8 busy write", int'(took), 0);
    end
    cur_req = "R8";
    rdy_mode = 1;
    drain();
    send(4);       // old entry: single 0, stay in state 0
    drain();
    chk(m_state == 0, "R8 state model", m_state, 0);
    wr(0, 4, 7, 8'hFF, 5, took);
    send(4);       // new entry now
    send(4);       // state 5 default entry
    drain();

    // random codebooks and random stream under random backpressure
    cur_req = "R5 random";
    for (int s = 0; s < 32; s++)
      for (int c = 0; c < 16; c++)
        wr(s, c, int'($urandom % 8), int'($urandom % 256), int'($urandom % 32), took);
    rdy_mode = 0;
    for (int i = 0; i < 400; i++) send(int'($urandom % 16));
    rdy_mode = 1;
    drain();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule